// File: doc/BRIEF.md
# Transactional Conflict Detector

This block follows hardware transactions for a small, fixed group of processors. Each processor has three strobes: one to start a transaction, one to finish it, and one to report an I/O attempt. Each processor also has a memory access port that carries an address and a write flag. For every live transaction the block keeps the addresses it has read and the addresses it has written, in two separate small associative sets. Each new access is compared, in the same cycle, with the sets of every other live transaction.

When an access overlaps another transaction in a way that breaks serializability, the block raises a conflict for the accessing processor and names the other processor. An external arbiter answers in the same cycle with a single bit that says whether the accessing side survives. The losing transaction is rolled back. It gets an abort pulse, loses its identifier, and has its sets emptied. The reason for the rollback is stored and returned as the status of that processor's next start. Three events force a rollback: losing a conflict, an I/O attempt, or a set that runs out of room. Each has its own status code.

A processor that reaches its finish strobe without being rolled back commits. The commit pulse, the cleared sets and the zeroed identifier all appear one cycle after the strobe.

Top module: `tx_conflict_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, every identifier reads zero, every start status reads 0, no commit or abort pulse is high and no conflict is raised.
- R2: A start strobe on an idle processor makes its identifier nonzero one cycle later. Two processors that start in the same cycle get different identifiers. A start strobe on a processor that is already in a transaction is ignored, and its identifier does not change.
- R3: A finish strobe on a live transaction gives a one-cycle commit pulse in the following cycle. In that same cycle the identifier reads zero. Its read and write sets are emptied, so its old addresses never cause later conflicts.
- R4: An access conflicts with another live transaction in two cases: it is a write that hits that transaction's read set or write set, or it is a read that hits that transaction's write set. A read that hits only another transaction's read set never conflicts.
- R5: A conflict raises the conflict flag of the accessing processor in the same cycle as the access, with the other processor's index on the peer output. If several transactions are involved, the lowest-numbered one is named. The arbiter bit 1 means the accessing side survives and 0 means the named side survives. The loser sees an abort pulse in the next cycle, with its identifier zero. The survivor gets no abort pulse.
- R6: An I/O strobe during a live transaction gives an abort pulse in the next cycle. Its effect on the status is given in R9.
- R7: Each set holds 8 distinct addresses. An access to an address already in the target set does not use a new entry. A 9th distinct address for the same set aborts the transaction in the next cycle.
- R8: If two processors access the same address in the same cycle and at least one of them writes, the lower-numbered access counts as first. Only the higher-numbered processor raises a conflict, and it names the lower one as its peer.
- R9: The start status is 2 bits: 0 means clean start or previous commit, 1 means lost a conflict, 2 means I/O needing exclusive execution, and 3 means set overflow. A start after a rollback returns that rollback's code. The start after that returns 0.
- R10: A transaction rolled back by a conflict has its sets emptied. A later transaction that touches the same addresses does not conflict with anything the rolled-back transaction held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin_i | input | NCPU | Per-processor start strobe |
| tx_end_i | input | NCPU | Per-processor finish strobe |
| io_try_i | input | NCPU | Per-processor I/O attempt strobe |
| acc_valid_i | input | NCPU | Per-processor access valid |
| acc_write_i | input | NCPU | Per-processor access is a write |
| acc_addr_i | input | NCPU*AW | Per-processor access address, processor i at bits i*AW upward |
| arb_req_wins_i | input | NCPU | Arbiter decision per accessing processor, 1 = accessing side survives |
| conf_valid_o | output | NCPU | Conflict raised by this processor's access, same cycle |
| conf_peer_o | output | NCPU*IDW | Index of the other processor in the conflict |
| begin_status_o | output | NCPU*2 | Status returned by the latest start |
| txid_o | output | NCPU*TXID_W | Current transaction identifier, zero when idle |
| commit_o | output | NCPU | One-cycle commit pulse |
| abort_o | output | NCPU | One-cycle abort pulse |

## Verification
The bench targets the asymmetric overlap rule. If read-over-read were flagged, concurrent readers would be aborted for no reason. If read-over-write were missed, a stale value would be committed. The bench checks that the arbiter bit selects the correct loser, since a swapped sense would abort the winner and keep the transaction that should have rolled back. It checks that sets are emptied after commit and after abort, because a leftover entry would raise a conflict in an unrelated later transaction. It also probes the ninth distinct address against a repeated one, the one-shot behaviour of the start status, and the same-cycle ordering by processor number, where reversed ordering would name the wrong peer.

// File: rtl/tx_pkg.sv
// Shared types for the transactional conflict detector.
package tx_pkg;
    // Restart reason returned as the start status.
    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_CONFLICT  = 2'd1,
        ST_NEED_EXCL = 2'd2,
        ST_OVERFLOW  = 2'd3
    } tx_status_e;
endpackage

// File: rtl/tx_addr_set.sv
// Small associative address set: DEPTH entries of valid bit plus tag.
// Compares NPROBE addresses in parallel against the stored tags.
// Assumes the caller asserts ins only for an address that is absent and
// only when a free slot exists; clr has priority over ins.
module tx_addr_set #(
    parameter int AW     = 16,
    parameter int DEPTH  = 8,
    parameter int NPROBE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ins,
    input  logic [AW-1:0]        ins_addr,
    input  logic [NPROBE*AW-1:0] probe_addr,
    output logic [NPROBE-1:0]    probe_hit,
    output logic                 full
);
    localparam int SLW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld;
    logic [AW-1:0]    tag [DEPTH];
    logic [SLW-1:0]   free_idx;
    logic             has_free;

    // Pick the lowest free slot.
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int d = DEPTH - 1; d >= 0; d--) begin
            if (!vld[d]) begin
                free_idx = SLW'(d);
                has_free = 1'b1;
            end
        end
    end

    // Valid bits: cleared on reset or clear, set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n)                 vld <= '0;
        else if (clr)               vld <= '0;
        else if (ins && has_free)   vld[free_idx] <= 1'b1;
    end

    // Tag storage: written on insert, meaningful only where valid.
    always_ff @(posedge clk) begin
        if (ins && has_free && !clr) tag[free_idx] <= ins_addr;
    end

    assign full = &vld;

    // One comparator bank per probe address.
    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        always_comb begin
            probe_hit[p] = 1'b0;
            for (int d = 0; d < DEPTH; d++) begin
                if (vld[d] && (tag[d] == probe_addr[p*AW +: AW])) probe_hit[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_conflict_detect.sv
// Combinational conflict finder. For every accessing processor it checks
// the other live transactions' sets and the same-cycle accesses of
// lower-numbered processors, and names the lowest conflicting peer.
// Assumes hit vectors are indexed [owner*NCPU + prober].
module tx_conflict_detect #(
    parameter int NCPU = 4,
    parameter int AW   = 16,
    parameter int IDW  = 2
) (
    input  logic [NCPU-1:0]      req_ok,
    input  logic [NCPU-1:0]      acc_write,
    input  logic [NCPU*AW-1:0]   acc_addr,
    input  logic [NCPU-1:0]      active,
    input  logic [NCPU*NCPU-1:0] rhit,
    input  logic [NCPU*NCPU-1:0] whit,
    input  logic [NCPU-1:0]      ovf,
    output logic [NCPU-1:0]      conf_valid,
    output logic [NCPU*IDW-1:0]  conf_peer
);
    // One search per accessing processor.
    for (genvar i = 0; i < NCPU; i++) begin : g_req
        logic           found;
        logic [IDW-1:0] peer;
        logic           stored_hit;
        logic           same_hit;

        // Scan peers from lowest index; first match is reported.
        always_comb begin
            found      = 1'b0;
            peer       = '0;
            stored_hit = 1'b0;
            same_hit   = 1'b0;
            for (int j = 0; j < NCPU; j++) begin
                if (j != i && active[j]) begin
                    stored_hit = acc_write[i] ? (rhit[j*NCPU+i] | whit[j*NCPU+i])
                                              : whit[j*NCPU+i];
                    same_hit   = (j < i) && req_ok[j]
                               && (acc_addr[j*AW +: AW] == acc_addr[i*AW +: AW])
                               && (acc_write[i] || acc_write[j]);
                    if (!found && (stored_hit || same_hit)) begin
                        found = 1'b1;
                        peer  = IDW'(j);
                    end
                end
            end
        end

        assign conf_valid[i]           = found & req_ok[i] & ~ovf[i];
        assign conf_peer[i*IDW +: IDW] = peer;
    end
endmodule

// File: rtl/tx_cpu_ctrl.sv
// Per-processor transaction state: live flag, identifier, start status,
// pending restart reason and the registered commit/abort pulses.
// Assumes kill_i is only asserted while the transaction is live.
module tx_cpu_ctrl
    import tx_pkg::*;
#(
    parameter int TXID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_i,
    input  logic              end_i,
    input  logic              kill_i,
    input  tx_status_e        kill_reason_i,
    input  logic [TXID_W-1:0] new_txid_i,
    output logic              active_o,
    output logic              begin_ok_o,
    output logic [TXID_W-1:0] txid_o,
    output tx_status_e        status_o,
    output logic              commit_o,
    output logic              abort_o
);
    tx_status_e pending;

    assign begin_ok_o = begin_i & ~active_o;

    // Transaction lifecycle: start, rollback or commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            txid_o   <= '0;
            status_o <= ST_OK;
            pending  <= ST_OK;
            commit_o <= 1'b0;
            abort_o  <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            abort_o  <= 1'b0;
            if (!active_o) begin
                if (begin_i) begin
                    active_o <= 1'b1;
                    txid_o   <= new_txid_i;
                    status_o <= pending;
                    pending  <= ST_OK;
                end
            end else if (kill_i) begin
                active_o <= 1'b0;
                txid_o   <= '0;
                abort_o  <= 1'b1;
                pending  <= kill_reason_i;
            end else if (end_i) begin
                active_o <= 1'b0;
                txid_o   <= '0;
                commit_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_conflict_unit.sv
// Top of the transactional conflict detector. Holds a read set and a
// write set per processor, detects overlaps at access time, asks the
// external arbiter for the survivor and rolls back the loser.
// Assumes the arbiter answers combinationally in the access cycle.
module tx_conflict_unit
    import tx_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int AW     = 16,
    parameter int DEPTH  = 8,
    parameter int TXID_W = 8,
    parameter int IDW    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCPU-1:0]         tx_begin_i,
    input  logic [NCPU-1:0]         tx_end_i,
    input  logic [NCPU-1:0]         io_try_i,
    input  logic [NCPU-1:0]         acc_valid_i,
    input  logic [NCPU-1:0]         acc_write_i,
    input  logic [NCPU*AW-1:0]      acc_addr_i,
    input  logic [NCPU-1:0]         arb_req_wins_i,
    output logic [NCPU-1:0]         conf_valid_o,
    output logic [NCPU*IDW-1:0]     conf_peer_o,
    output logic [NCPU*2-1:0]       begin_status_o,
    output logic [NCPU*TXID_W-1:0]  txid_o,
    output logic [NCPU-1:0]         commit_o,
    output logic [NCPU-1:0]         abort_o
);
    localparam int SEQW = TXID_W - IDW;

    logic [NCPU-1:0]      active, begin_ok, req_ok, ovf, kill;
    logic [NCPU-1:0]      lost_hold, lost_req, clr, ins_r, ins_w;
    logic [NCPU-1:0]      rfull, wfull, own_r, own_w;
    logic [NCPU*NCPU-1:0] rhit, whit;
    logic [SEQW-1:0]      seq;

    // Identifier sequence: nonzero, advances on any accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)              seq <= SEQW'(1);
        else if (|begin_ok)      seq <= (&seq) ? SEQW'(1) : seq + SEQW'(1);
    end

    tx_conflict_detect #(.NCPU(NCPU), .AW(AW), .IDW(IDW)) detect_i (
        .req_ok     (req_ok),
        .acc_write  (acc_write_i),
        .acc_addr   (acc_addr_i),
        .active     (active),
        .rhit       (rhit),
        .whit       (whit),
        .ovf        (ovf),
        .conf_valid (conf_valid_o),
        .conf_peer  (conf_peer_o)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        tx_status_e status;
        tx_status_e reason;

        // Only a live transaction without an I/O attempt makes an access.
        assign req_ok[i] = acc_valid_i[i] & active[i] & ~io_try_i[i];

        tx_addr_set #(.AW(AW), .DEPTH(DEPTH), .NPROBE(NCPU)) rset_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr[i]),
            .ins        (ins_r[i]),
            .ins_addr   (acc_addr_i[i*AW +: AW]),
            .probe_addr (acc_addr_i),
            .probe_hit  (rhit[i*NCPU +: NCPU]),
            .full       (rfull[i])
        );

        tx_addr_set #(.AW(AW), .DEPTH(DEPTH), .NPROBE(NCPU)) wset_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr[i]),
            .ins        (ins_w[i]),
            .ins_addr   (acc_addr_i[i*AW +: AW]),
            .probe_addr (acc_addr_i),
            .probe_hit  (whit[i*NCPU +: NCPU]),
            .full       (wfull[i])
        );

        assign own_r[i] = rhit[i*NCPU + i];
        assign own_w[i] = whit[i*NCPU + i];

        // Overflow: new distinct address for a full target set.
        assign ovf[i] = req_ok[i] & (acc_write_i[i] ? (wfull[i] & ~own_w[i])
                                                    : (rfull[i] & ~own_r[i]));

        // Holder side loses when an accessor naming it wins arbitration.
        always_comb begin
            lost_hold[i] = 1'b0;
            for (int k = 0; k < NCPU; k++) begin
                if (conf_valid_o[k] && arb_req_wins_i[k]
                    && (conf_peer_o[k*IDW +: IDW] == IDW'(i)))
                    lost_hold[i] = 1'b1;
            end
        end

        assign lost_req[i] = conf_valid_o[i] & ~arb_req_wins_i[i];
        assign kill[i]     = active[i] & (io_try_i[i] | ovf[i] | lost_req[i] | lost_hold[i]);

        // Reason priority: I/O, then overflow, then conflict.
        always_comb begin
            if (io_try_i[i])  reason = ST_NEED_EXCL;
            else if (ovf[i])  reason = ST_OVERFLOW;
            else              reason = ST_CONFLICT;
        end

        assign clr[i]   = kill[i] | (active[i] & tx_end_i[i]);
        assign ins_r[i] = req_ok[i] & ~acc_write_i[i] & ~kill[i] & ~own_r[i];
        assign ins_w[i] = req_ok[i] &  acc_write_i[i] & ~kill[i] & ~own_w[i];

        tx_cpu_ctrl #(.TXID_W(TXID_W)) ctrl_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .begin_i       (tx_begin_i[i]),
            .end_i         (tx_end_i[i]),
            .kill_i        (kill[i]),
            .kill_reason_i (reason),
            .new_txid_i    ({seq, IDW'(i)}),
            .active_o      (active[i]),
            .begin_ok_o    (begin_ok[i]),
            .txid_o        (txid_o[i*TXID_W +: TXID_W]),
            .status_o      (status),
            .commit_o      (commit_o[i]),
            .abort_o       (abort_o[i])
        );

        assign begin_status_o[i*2 +: 2] = status;
    end
endmodule

// File: rtl/tx_conflict_checker.sv
// Property checker for tx_conflict_unit, attached by bind.
// Observes only the top-level ports.
module tx_conflict_checker #(
    parameter int NCPU   = 4,
    parameter int TXID_W = 8,
    parameter int IDW    = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCPU-1:0]        tx_begin_i,
    input logic [NCPU-1:0]        io_try_i,
    input logic [NCPU-1:0]        acc_valid_i,
    input logic [NCPU-1:0]        arb_req_wins_i,
    input logic [NCPU-1:0]        conf_valid_o,
    input logic [NCPU*IDW-1:0]    conf_peer_o,
    input logic [NCPU*TXID_W-1:0] txid_o,
    input logic [NCPU-1:0]        commit_o,
    input logic [NCPU-1:0]        abort_o
);
    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        assert_begin_gives_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_begin_i[i] && txid_o[i*TXID_W +: TXID_W] == '0)
            |=> (txid_o[i*TXID_W +: TXID_W] != '0));

        assert_commit_clears_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
            commit_o[i] |-> (txid_o[i*TXID_W +: TXID_W] == '0) && !abort_o[i]);

        assert_conf_needs_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
            conf_valid_o[i] |-> acc_valid_i[i]);

        assert_loser_accessor_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (conf_valid_o[i] && !arb_req_wins_i[i]) |=> abort_o[i]);

        assert_io_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (io_try_i[i] && txid_o[i*TXID_W +: TXID_W] != '0) |=> abort_o[i]);

        for (genvar j = 0; j < NCPU; j++) begin : g_peer
            assert_loser_holder_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (conf_valid_o[i] && arb_req_wins_i[i] && conf_peer_o[i*IDW +: IDW] == IDW'(j))
                |=> abort_o[j]);
        end
    end
endmodule

bind tx_conflict_unit tx_conflict_checker #(.NCPU(NCPU), .TXID_W(TXID_W), .IDW(IDW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_begin_i     (tx_begin_i),
    .io_try_i       (io_try_i),
    .acc_valid_i    (acc_valid_i),
    .arb_req_wins_i (arb_req_wins_i),
    .conf_valid_o   (conf_valid_o),
    .conf_peer_o    (conf_peer_o),
    .txid_o         (txid_o),
    .commit_o       (commit_o),
    .abort_o        (abort_o)
);

// File: tb/tx_conflict_unit_tb_top.sv
// Directed bench for tx_conflict_unit: one task per scenario.
module tx_conflict_unit_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NCPU = 4, AW = 16, TXW = 8, IDW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCPU-1:0] beg = '0, endv = '0, io = '0, av = '0, aw = '0, win = '0;
    logic [NCPU*AW-1:0] addr = '0;
    logic [NCPU-1:0] conf, commit, abrt;
    logic [NCPU*IDW-1:0] peer;
    logic [NCPU*2-1:0] stat;
    logic [NCPU*TXW-1:0] txid;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    tx_conflict_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tx_begin_i(beg), .tx_end_i(endv), .io_try_i(io),
        .acc_valid_i(av), .acc_write_i(aw), .acc_addr_i(addr), .arb_req_wins_i(win),
        .conf_valid_o(conf), .conf_peer_o(peer), .begin_status_o(stat), .txid_o(txid),
        .commit_o(commit), .abort_o(abrt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Advance one cycle, then drop all strobes.
    task automatic tick();
        @(negedge clk);
        beg = '0; endv = '0; io = '0; av = '0; aw = '0; win = '0;
    endtask

    task automatic acc(input int c, input logic wr, input logic [AW-1:0] a);
        av[c] = 1'b1; aw[c] = wr; addr[c*AW +: AW] = a;
    endtask

    function automatic int id_of(input int c);
        return int'(txid[c*TXW +: TXW]);
    endfunction

    task automatic t_reset();
        chk("R1 txids zero", int'(txid), 0);
        chk("R1 status zero", int'(stat), 0);
        chk("R1 no pulses", int'({commit, abrt}), 0);
        chk("R1 no conflict", int'(conf), 0);
    endtask

    task automatic t_begin_commit();
        beg[0] = 1'b1; tick();
        chk("R2 id nonzero", int'(id_of(0) != 0), 1);
        chk("R9 fresh status", int'(stat[1:0]), 0);
        acc(0, 1'b1, 16'h0D0); tick();
        endv[0] = 1'b1; tick();
        chk("R3 commit pulse", int'(commit[0]), 1);
        chk("R3 id zero", id_of(0), 0);
        tick();
        chk("R3 pulse one cycle", int'(commit[0]), 0);
        beg[0] = 1'b1; beg[1] = 1'b1; tick();
        chk("R2 distinct ids", int'(id_of(0) != id_of(1)), 1);
        acc(1, 1'b0, 16'h0D0); #1;
        chk("R3 committed set cleared", int'(conf[1]), 0);
        tick();
        endv[0] = 1'b1; endv[1] = 1'b1; tick();
        chk("R3 both commit", int'(commit[1:0]), 3);
    endtask

    task automatic t_read_read();
        beg[0] = 1'b1; beg[1] = 1'b1; tick();
        acc(0, 1'b0, 16'h0E0); tick();
        acc(1, 1'b0, 16'h0E0); #1;
        chk("R4 read/read no conflict", int'(conf), 0);
        tick();
        endv[0] = 1'b1; endv[1] = 1'b1; tick();
        chk("R4 readers commit", int'(commit[1:0]), 3);
        chk("R4 no abort", int'(abrt), 0);
    endtask

    task automatic t_holder_wins();
        beg[0] = 1'b1; beg[1] = 1'b1; tick();
        acc(0, 1'b0, 16'h0A0); tick();
        acc(1, 1'b1, 16'h0A0); win[1] = 1'b0; #1;
        chk("R4 write over read conflicts", int'(conf[1]), 1);
        chk("R5 peer index", int'(peer[1*IDW +: IDW]), 0);
        tick();
        chk("R5 accessor aborted", int'(abrt[1]), 1);
        chk("R5 holder survives", int'(abrt[0]), 0);
        chk("R5 loser id zero", id_of(1), 0);
        endv[0] = 1'b1; beg[1] = 1'b1; tick();
        chk("R5 survivor commits", int'(commit[0]), 1);
        chk("R9 conflict status", int'(stat[3:2]), 1);
        endv[1] = 1'b1; tick();
        beg[1] = 1'b1; tick();
        chk("R9 status one-shot", int'(stat[3:2]), 0);
        endv[1] = 1'b1; tick();
    endtask

    task automatic t_accessor_wins();
        beg[0] = 1'b1; beg[1] = 1'b1; tick();
        acc(0, 1'b1, 16'h0B0); tick();
        acc(1, 1'b0, 16'h0B0); win[1] = 1'b1; #1;
        chk("R4 read over write conflicts", int'(conf[1]), 1);
        tick();
        chk("R5 holder aborted", int'(abrt[0]), 1);
        chk("R5 accessor survives", int'(abrt[1]), 0);
        endv[1] = 1'b1; tick();
        chk("R5 winner commits", int'(commit[1]), 1);
        beg[0] = 1'b1; beg[1] = 1'b1; tick();
        chk("R9 conflict status holder", int'(stat[1:0]), 1);
        acc(1, 1'b1, 16'h0B0); #1;
        chk("R10 aborted set cleared", int'(conf[1]), 0);
        tick();
        endv[0] = 1'b1; endv[1] = 1'b1; tick();
    endtask

    task automatic t_io();
        beg[2] = 1'b1; tick();
        io[2] = 1'b1; tick();
        chk("R6 io abort", int'(abrt[2]), 1);
        chk("R6 id zero", id_of(2), 0);
        beg[2] = 1'b1; tick();
        chk("R9 need-exclusive status", int'(stat[5:4]), 2);
        endv[2] = 1'b1; tick();
        chk("R6 commit after retry", int'(commit[2]), 1);
    endtask

    task automatic t_overflow();
        int aborted = 0;
        beg[3] = 1'b1; tick();
        for (int k = 0; k < 8; k++) begin
            acc(3, 1'b1, 16'h100 + 16'(k)); tick();
            aborted += int'(abrt[3]);
        end
        acc(3, 1'b1, 16'h100); tick();
        aborted += int'(abrt[3]);
        acc(3, 1'b0, 16'h200); tick();
        aborted += int'(abrt[3]);
        chk("R7 eight entries and repeat fit", aborted, 0);
        acc(3, 1'b1, 16'h108); tick();
        chk("R7 ninth address aborts", int'(abrt[3]), 1);
        beg[3] = 1'b1; tick();
        chk("R9 overflow status", int'(stat[7:6]), 3);
        endv[3] = 1'b1; tick();
    endtask

    task automatic t_ignored_begin();
        int first;
        beg[2] = 1'b1; tick();
        first = id_of(2);
        beg[2] = 1'b1; tick();
        chk("R2 begin while live ignored", id_of(2), first);
        endv[2] = 1'b1; tick();
        chk("R2 commit of original", int'(commit[2]), 1);
    endtask

    task automatic t_same_cycle();
        beg[0] = 1'b1; beg[1] = 1'b1; tick();
        acc(0, 1'b1, 16'h300); acc(1, 1'b1, 16'h300); win[1] = 1'b0; #1;
        chk("R8 lower access first", int'(conf[1:0]), 2);
        chk("R8 peer is lower", int'(peer[1*IDW +: IDW]), 0);
        tick();
        chk("R8 higher aborted", int'(abrt[1:0]), 2);
        endv[0] = 1'b1; tick();
        chk("R8 lower commits", int'(commit[0]), 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_begin_commit();
        t_read_read();
        t_holder_wins();
        t_accessor_wins();
        t_io();
        t_overflow();
        t_ignored_begin();
        t_same_cycle();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule